// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C slave that fronts a 2048-byte internal memory. The memory is split into eight blocks of 256 bytes, and each block holds sixteen pages of 16 bytes. SCL and SDA are sampled by the system clock through two-flop synchronizers, and every bus event is taken from the synchronized levels. SDA is driven only through an output enable that pulls the line low. The surrounding logic supplies the pull-up, forming a wired-AND with the master.

A transaction opens with a START. The first byte carries a 4-bit type code, a 3-bit block number and the read/write flag. For a write, a byte address follows, and then data bytes. The data bytes are collected in a one-page buffer and reach the array only after a STOP. For a read, bytes stream out from an internal pointer. The master reaches any location by sending a dummy write of the byte address and then a repeated START. A write-protect input keeps the upper half of the array from being programmed, and reads of that half still work.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: Before a START, and after any transaction has ended, the slave ignores SCL/SDA activity and never pulls SDA low. A START is seen at any time outside the commit window.
- R2: The first byte after a START is `1010 b2 b1 b0 rw`, sent MSB first: type code 1010, block number in bits 3..1, and bit 0 set to 1 for a read. Any other type code gets no acknowledge, and the slave goes idle until the next START.
- R3: After a matching first byte, after the byte address, and after each accepted data byte, the slave holds SDA low for the whole ninth SCL clock. It releases SDA once that clock falls.
- R4: A single data byte followed by STOP is stored at address {block, byte address}. The write finishes within 20 system clocks after the STOP.
- R5: During a write, the low 4 address bits advance after each data byte and wrap inside the current 16-byte page. Beyond 16 bytes, a later byte overwrites the earlier byte in the same slot.
- R6: Buffered bytes are written only when the STOP comes at a byte boundary. If the STOP comes part-way through a data byte, or a repeated START comes during the data phase, the whole write is dropped.
- R7: A read that is not preceded by a byte address begins at {block from the first byte, low 8 bits of the internal pointer}. The pointer rests one past the last byte read, or one past the last byte written, with the write pointer wrapping within its page.
- R8: On a read, each master ACK makes the slave send the next byte. The address advances across the full 2048-byte space and wraps from 0x7FF to 0x000. A master NACK followed by STOP ends the read.
- R9: A dummy write of block and byte address, followed by a repeated START and a read byte with the same block, returns the data at that address.
- R10: With write protect high, a data byte aimed at the upper half (blocks 4 to 7, address bit 10 set) gets no acknowledge and is not stored. The first byte and the byte address are still acknowledged. The lower half stays writable, and every location stays readable.
- R11: With write protect low, the upper half is written like the lower half.
- R12: The SDA output enable is 0 after reset, and it only ever starts driving low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level as seen on the wired line |
| wpIn | input | 1 | Write-protect level for the upper half |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, apart from START and STOP. Each SCL phase and each SDA setup spans several system clocks, so a synchronized SDA edge never lands in the same cycle as a synchronized SCL edge. Write protect is held steady for the length of a transaction. The master model in the bench keeps to these rules: it spaces every bus change five system clocks apart, changes data a quarter period after SCL falls, and changes write protect only between transactions. Random writes and reads are mixed with directed cases for the wrap points, aborted writes and protected blocks.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef struct packed {
    logic shiftIn;
    logic setBlock;
    logic loadByteAddr;
    logic bufWrite;
    logic bufClear;
    logic loadTx;
    logic shiftTx;
    logic commitGo;
  } dpStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT,
    ST_COMMIT
  } busState_t;

endpackage

// File: rtl/eeprom_sync.sv
module eeprom_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ[s] <= '1;
      end else if (s == 0) begin
        stageQ[s] <= asyncIn;
      end else begin
        stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_pkg::*;
#(
  parameter int BLOCK_BITS = 3,
  parameter int PAGE_BITS  = 4,
  parameter int WORD_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdaS,
  input  logic                 wpIn,
  input  dpStrobe_t            strb,
  output logic [WORD_BITS-1:0] rxByte,
  output logic                 txBit,
  output logic                 addrUpper,
  output logic                 commitDone
);

  localparam int ADDR_W    = BLOCK_BITS + WORD_BITS;
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int PAGE_LEN  = 1 << PAGE_BITS;

  logic [WORD_BITS-1:0] memArr  [MEM_DEPTH];
  logic [WORD_BITS-1:0] pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0]  slotValid;
  logic [WORD_BITS-1:0] rxShift;
  logic [WORD_BITS-1:0] txShift;
  logic [ADDR_W-1:0]    addrQ;
  logic                 committing;
  logic [PAGE_BITS-1:0] commitSlot;

  // receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strb.shiftIn) begin
      rxShift <= {rxShift[WORD_BITS-2:0], sdaS};
    end
  end

  // address pointer and transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      txShift <= '1;
    end else begin
      if (strb.setBlock) begin
        addrQ[ADDR_W-1 -: BLOCK_BITS] <= rxShift[BLOCK_BITS:1];
      end else if (strb.loadByteAddr) begin
        addrQ[WORD_BITS-1:0] <= rxShift;
      end else if (strb.bufWrite) begin
        addrQ[PAGE_BITS-1:0] <= addrQ[PAGE_BITS-1:0] + 1'b1;
      end else if (strb.loadTx) begin
        addrQ <= addrQ + 1'b1;
      end
      if (strb.loadTx) begin
        txShift <= memArr[addrQ];
      end else if (strb.shiftTx) begin
        txShift <= {txShift[WORD_BITS-2:0], 1'b1};
      end
    end
  end

  // page buffer contents
  always_ff @(posedge clk) begin
    if (strb.bufWrite) begin
      pageBuf[addrQ[PAGE_BITS-1:0]] <= rxShift;
    end
  end

  for (genvar g = 0; g < PAGE_LEN; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid[g] <= 1'b0;
      end else if (strb.bufClear || commitDone) begin
        slotValid[g] <= 1'b0;
      end else if (strb.bufWrite && addrQ[PAGE_BITS-1:0] == PAGE_BITS'(g)) begin
        slotValid[g] <= 1'b1;
      end
    end
  end

  // commit sequencer: one page slot per clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      committing <= 1'b0;
      commitSlot <= '0;
      commitDone <= 1'b0;
    end else begin
      commitDone <= 1'b0;
      if (strb.commitGo) begin
        committing <= 1'b1;
        commitSlot <= '0;
      end else if (committing) begin
        commitSlot <= commitSlot + 1'b1;
        if (commitSlot == PAGE_BITS'(PAGE_LEN-1)) begin
          committing <= 1'b0;
          commitDone <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (committing && slotValid[commitSlot]) begin
      memArr[{addrQ[ADDR_W-1:PAGE_BITS], commitSlot}] <= pageBuf[commitSlot];
    end
  end

  assign rxByte    = rxShift;
  assign txBit     = txShift[WORD_BITS-1];
  assign addrUpper = addrQ[ADDR_W-1];

  p_wp_guard_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufWrite |-> !(wpIn && addrQ[ADDR_W-1]));

  p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufWrite |=> addrQ[ADDR_W-1:PAGE_BITS] == $past(addrQ[ADDR_W-1:PAGE_BITS]));

  p_read_advance_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |=> addrQ == $past(addrQ) + 1'b1);

  p_commit_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    committing |-> !strb.bufWrite && !strb.loadByteAddr);

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int                  WORD_BITS = 8,
  parameter int                  TYPE_BITS = 4,
  parameter logic [TYPE_BITS-1:0] DEV_TYPE = 4'b1010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclS,
  input  logic                 sdaS,
  input  logic                 wpIn,
  input  logic [WORD_BITS-1:0] rxByte,
  input  logic                 addrUpper,
  input  logic                 commitDone,
  output dpStrobe_t            strb,
  output logic                 ackDrive,
  output logic                 txActive
);

  localparam int CNT_W = $clog2(WORD_BITS + 1);

  busState_t  state, stateN;
  logic [CNT_W-1:0] bitCnt, bitCntN;
  logic ackN, txN, isRead, readN, mAck, mAckN;
  logic sclPrev, sdaPrev;
  logic sclRise, sclFall, startEv, stopEv, byteDone;

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startEv  = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv   = sclS & sclPrev & ~sdaPrev & sdaS;
  assign byteDone = sclFall && (bitCnt == CNT_W'(WORD_BITS));

  always_comb begin
    stateN  = state;
    bitCntN = bitCnt;
    ackN    = ackDrive;
    txN     = txActive;
    readN   = isRead;
    mAckN   = mAck;
    strb    = '0;
    if (state == ST_COMMIT) begin
      if (commitDone) stateN = ST_IDLE;
    end else if (startEv) begin
      stateN        = ST_DEV;
      bitCntN       = '0;
      ackN          = 1'b0;
      txN           = 1'b0;
      strb.bufClear = 1'b1;
    end else if (stopEv) begin
      ackN = 1'b0;
      txN  = 1'b0;
      // the STOP's own SCL rise counts one bit; at most one means byte boundary
      if (state == ST_DATA && bitCnt <= CNT_W'(1)) begin
        stateN        = ST_COMMIT;
        strb.commitGo = 1'b1;
      end else begin
        stateN        = ST_IDLE;
        strb.bufClear = 1'b1;
      end
    end else begin
      unique case (state)
        ST_DEV, ST_WADDR, ST_DATA: begin
          if (sclRise && bitCnt < CNT_W'(WORD_BITS)) begin
            strb.shiftIn = 1'b1;
            bitCntN      = bitCnt + 1'b1;
          end else if (byteDone) begin
            bitCntN = '0;
            if (state == ST_DEV) begin
              if (rxByte[WORD_BITS-1 -: TYPE_BITS] == DEV_TYPE) begin
                ackN          = 1'b1;
                strb.setBlock = 1'b1;
                readN         = rxByte[0];
                stateN        = ST_DEV_ACK;
              end else begin
                stateN = ST_IDLE;
              end
            end else if (state == ST_WADDR) begin
              ackN              = 1'b1;
              strb.loadByteAddr = 1'b1;
              stateN            = ST_WADDR_ACK;
            end else if (wpIn && addrUpper) begin
              stateN = ST_WAIT;
            end else begin
              ackN          = 1'b1;
              strb.bufWrite = 1'b1;
              stateN        = ST_DATA_ACK;
            end
          end
        end
        ST_DEV_ACK, ST_WADDR_ACK, ST_DATA_ACK: begin
          if (sclFall) begin
            ackN    = 1'b0;
            bitCntN = '0;
            if (state == ST_DEV_ACK && isRead) begin
              strb.loadTx = 1'b1;
              txN         = 1'b1;
              stateN      = ST_TX;
            end else if (state == ST_DEV_ACK) begin
              stateN = ST_WADDR;
            end else begin
              stateN = ST_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            bitCntN = bitCnt + 1'b1;
          end else if (byteDone) begin
            txN     = 1'b0;
            bitCntN = '0;
            stateN  = ST_MACK;
          end else if (sclFall) begin
            strb.shiftTx = 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            mAckN = ~sdaS;
          end else if (sclFall) begin
            if (mAck) begin
              strb.loadTx = 1'b1;
              txN         = 1'b1;
              stateN      = ST_TX;
            end else begin
              stateN = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
      isRead   <= 1'b0;
      mAck     <= 1'b0;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      ackDrive <= ackN;
      txActive <= txN;
      isRead   <= readN;
      mAck     <= mAckN;
      sclPrev  <= sclS;
      sdaPrev  <= sdaS;
    end
  end

  p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_WAIT) |-> !ackDrive && !txActive);

  p_bad_type_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && byteDone && !startEv && !stopEv &&
     rxByte[WORD_BITS-1 -: TYPE_BITS] != DEV_TYPE) |=> (state == ST_IDLE) && !ackDrive);

  p_ack_scl_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> !sclS);

  p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stopEv && state != ST_COMMIT) |=> (state == ST_IDLE || state == ST_COMMIT));

  p_single_driver_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(ackDrive && txActive));

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_pkg::*;
#(
  parameter int                   BLOCK_BITS  = 3,
  parameter int                   PAGE_BITS   = 4,
  parameter int                   WORD_BITS   = 8,
  parameter int                   TYPE_BITS   = 4,
  parameter logic [TYPE_BITS-1:0] DEV_TYPE    = 4'b1010,
  parameter int                   SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wpIn,
  output logic sdaOe
);

  logic [1:0]           busSync;
  logic                 sclS, sdaS;
  dpStrobe_t            strb;
  logic [WORD_BITS-1:0] rxByte;
  logic                 txBit, addrUpper, commitDone, ackDrive, txActive;

  eeprom_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn({sclIn, sdaIn}), .syncOut(busSync)
  );
  assign sclS = busSync[1];
  assign sdaS = busSync[0];

  eeprom_ctrl #(.WORD_BITS(WORD_BITS), .TYPE_BITS(TYPE_BITS), .DEV_TYPE(DEV_TYPE)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .wpIn(wpIn),
    .rxByte(rxByte), .addrUpper(addrUpper), .commitDone(commitDone),
    .strb(strb), .ackDrive(ackDrive), .txActive(txActive)
  );

  eeprom_dp #(.BLOCK_BITS(BLOCK_BITS), .PAGE_BITS(PAGE_BITS), .WORD_BITS(WORD_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .wpIn(wpIn), .strb(strb),
    .rxByte(rxByte), .txBit(txBit), .addrUpper(addrUpper), .commitDone(commitDone)
  );

  assign sdaOe = ackDrive | (txActive & ~txBit);

  p_drive_on_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS);

endmodule

// File: tb/eeprom_i2c_slave_tb.sv
module eeprom_i2c_slave_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSdaLow = 1'b0;
  logic wp = 1'b0;
  logic sdaOe;
  logic sdaBus;
  assign sdaBus = !(mSdaLow | sdaOe);

  eeprom_i2c_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .wpIn(wp), .sdaOe(sdaOe)
  );

  localparam int Q = 5;
  int nTests = 0;
  int nFail = 0;
  int badRise = 0;
  logic oeD = 1'b0;
  logic [7:0] refMem [0:2047];
  bit refKnown [0:2047];
  logic [7:0] wbuf [0:31];
  logic [10:0] refPtr = '0;

  always @(negedge clk) begin
    if (sdaOe && !oeD && mScl) badRise++;
    oeD <= sdaOe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    mSdaLow = 1'b0; tick(Q); mScl = 1'b1; tick(2*Q);
    mSdaLow = 1'b1; tick(2*Q); mScl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; tick(Q); mScl = 1'b1; tick(2*Q);
    mSdaLow = 1'b0; tick(2*Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mSdaLow = !b[i]; tick(Q); mScl = 1'b1; tick(2*Q); mScl = 1'b0; tick(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    mSdaLow = 1'b0; tick(Q); mScl = 1'b1; tick(Q);
    acked = !sdaBus;
    tick(Q); mScl = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    mSdaLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); mScl = 1'b1; tick(Q); b[i] = sdaBus; tick(Q); mScl = 1'b0;
    end
    tick(Q);
    mSdaLow = ackIt; tick(Q); mScl = 1'b1; tick(2*Q); mScl = 1'b0; tick(Q);
    mSdaLow = 1'b0;
  endtask

  function automatic logic [10:0] slotAddr(input logic [2:0] blk, input logic [7:0] ad, input int i);
    logic [3:0] lo;
    lo = ad[3:0] + 4'(i);
    return {blk, ad[7:4], lo};
  endfunction

  task automatic doWrite(input logic [2:0] blk, input logic [7:0] ad, input int len);
    bit a;
    bit prot;
    string tag;
    prot = wp && blk[2];
    tag = prot ? "R10" : (blk[2] ? "R11" : "R4");
    busStart();
    sendByte({4'hA, blk, 1'b0}, a); check(a, "R2 type ack", int'(a), 1);
    sendByte(ad, a); check(a, "R3 address ack", int'(a), 1);
    for (int i = 0; i < len; i++) begin
      sendByte(wbuf[i], a);
      if (prot) begin
        check(!a, "R10 protected data nack", int'(a), 0);
        break;
      end
      check(a, {tag, " data ack"}, int'(a), 1);
    end
    busStop(); tick(40);
    if (!prot) begin
      for (int i = 0; i < len; i++) begin
        refMem[slotAddr(blk, ad, i)] = wbuf[i];
        refKnown[slotAddr(blk, ad, i)] = 1'b1;
      end
      refPtr = slotAddr(blk, ad, len);
    end else begin
      refPtr = {blk, ad};
    end
  endtask

  task automatic doRead(input logic [10:0] startIn, input int n, input bit useCurrent, input string tag);
    bit a;
    logic [7:0] b;
    logic [10:0] st;
    logic [10:0] ad;
    if (useCurrent) begin
      st = refPtr;
      busStart();
      sendByte({4'hA, st[10:8], 1'b1}, a); check(a, "R7 read type ack", int'(a), 1);
    end else begin
      st = startIn;
      busStart();
      sendByte({4'hA, st[10:8], 1'b0}, a); check(a, "R9 dummy write ack", int'(a), 1);
      sendByte(st[7:0], a); check(a, "R9 address ack", int'(a), 1);
      busStart();
      sendByte({4'hA, st[10:8], 1'b1}, a); check(a, "R9 read type ack", int'(a), 1);
    end
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, b);
      ad = st + 11'(i);
      if (refKnown[ad]) check(b == refMem[ad], tag, int'(b), int'(refMem[ad]));
    end
    busStop(); tick(20);
    refPtr = st + 11'(n);
  endtask

  initial begin
    bit a;
    logic [7:0] oldVal;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++) refKnown[i] = 1'b0;
    tick(5); rstN = 1'b1; tick(5);
    check(sdaOe == 1'b0, "R12 reset release", int'(sdaOe), 0);

    // R1: traffic without START is ignored
    mScl = 1'b0; tick(Q);
    sendByte(8'hA0, a); check(!a, "R1 no start no ack", int'(a), 0);
    busStop(); tick(10);

    // R2: wrong type code, then slave stays idle
    busStart();
    sendByte(8'hB0, a); check(!a, "R2 wrong type nack", int'(a), 0);
    sendByte(8'hA0, a); check(!a, "R1 idle after bad type", int'(a), 0);
    busStop(); tick(10);

    // R4: byte write
    wbuf[0] = 8'h5C; doWrite(3'd1, 8'h22, 1);
    doRead(11'h122, 1, 1'b0, "R4 byte readback");

    // R7: full page then wrap of the pointer, current-address read
    for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'h40 + i);
    doWrite(3'd1, 8'h30, 16);
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; doWrite(3'd1, 8'h3E, 2);
    check(refPtr == 11'h130, "R7 bench pointer", int'(refPtr), 'h130);
    doRead(11'h0, 2, 1'b1, "R7 current read");

    // R5: more than a page wraps in the page
    for (int i = 0; i < 20; i++) wbuf[i] = 8'($urandom);
    doWrite(3'd2, 8'h5A, 20);
    doRead(11'h250, 16, 1'b0, "R5 page wrap data");

    // R6: STOP mid byte drops the write
    wbuf[0] = 8'h11; doWrite(3'd3, 8'h10, 1);
    oldVal = refMem[11'h310];
    busStart();
    sendByte(8'hA6, a); sendByte(8'h10, a);
    sendByte(8'h99, a); check(a, "R3 data ack before abort", int'(a), 1);
    sendBits(8'hFF, 3);
    busStop(); tick(40);
    doRead(11'h310, 1, 1'b0, "R6 stop mid byte");
    // R6: repeated START in data phase drops the write
    busStart();
    sendByte(8'hA6, a); sendByte(8'h10, a);
    sendByte(8'h77, a);
    doRead(11'h310, 1, 1'b0, "R6 repeated start");
    check(refMem[11'h310] == oldVal, "R6 reference intact", int'(refMem[11'h310]), int'(oldVal));

    // R10 / R11: write protect
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; doWrite(3'd5, 8'h80, 2);
    wp = 1'b1;
    wbuf[0] = 8'h00; wbuf[1] = 8'hFF; doWrite(3'd5, 8'h80, 2);
    doRead(11'h580, 2, 1'b0, "R10 protected unchanged");
    wbuf[0] = 8'h3C; doWrite(3'd2, 8'h07, 1);
    doRead(11'h207, 1, 1'b0, "R10 lower half writable");
    wp = 1'b0;
    wbuf[0] = 8'hC3; doWrite(3'd6, 8'hF0, 1);
    doRead(11'h6F0, 1, 1'b0, "R11 upper half writable");

    // R8: sequential read wraps from top to bottom
    for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'h90 + i);
    doWrite(3'd7, 8'hF8, 8);
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'h20 + i);
    doWrite(3'd0, 8'h00, 4);
    doRead(11'h7FC, 8, 1'b0, "R8 read wrap");

    // random mix
    for (int k = 0; k < 20; k++) begin
      logic [2:0] blk;
      logic [7:0] ad;
      int len;
      blk = 3'($urandom);
      ad  = 8'($urandom);
      if ($urandom % 2 == 0) begin
        len = 1 + int'($urandom % 18);
        wp  = 1'($urandom);
        for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
        doWrite(blk, ad, len);
        wp = 1'b0;
        doRead({blk, ad}, (len > 6) ? 6 : len, 1'b0, "R9 random readback");
      end else begin
        doRead({blk, ad}, 1 + int'($urandom % 6), 1'b0, "R8 random read");
      end
    end

    check(badRise == 0, "R12 drive began with SCL high", badRise, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule